// File: doc/BRIEF.md
# Framed SPI Sensor Polling Controller

This block is an SPI master that polls a position sensor with fixed frames of ten bytes. In every frame it shifts out one command byte followed by nine zero bytes. In the same full-duplex transfer it collects the ten bytes the sensor returns. The returned bytes are placed on a parallel output, and a one-cycle done strobe marks each completed frame. The serial link runs with the clock idling low. Data is launched on the rising edge and captured on the falling edge.

Two timing rules of the sensor are enforced in hardware:

- Chip select must stay low for a settling time before the first clock edge.
- Chip select must stay high for a long recovery gap between frames. A gap that is too short makes the sensor answer with a filler pattern instead of data.

Both times are given in nanoseconds together with the system clock frequency. They are turned into clock-cycle counts when the block is built, rounded up so the minimum is always met. The clock half-period is given directly in cycles.

A request pulse fetches one frame. A continuous-mode level keeps the block polling: each new frame starts as soon as the recovery gap has run out.

The controller is a five-state machine:

| State | What the block does |
|---|---|
| `ST_IDLE` | Chip select high, gap already satisfied |
| `ST_SETUP` | Chip select low, clock held low |
| `ST_HIGH` | Clock high half of a bit |
| `ST_LOW` | Clock low half of a bit |
| `ST_GAP` | Chip select high recovery |

Its transitions are:

| From | To | Condition | Action |
|---|---|---|---|
| `ST_IDLE` | `ST_SETUP` | request or continuous mode | — |
| `ST_SETUP` | `ST_HIGH` | settling timer expires | first bit is launched |
| `ST_HIGH` | `ST_LOW` | half-period expires | MISO is sampled |
| `ST_LOW` | `ST_HIGH` | half-period expires, more bits remain | next bit is launched |
| `ST_LOW` | `ST_GAP` | half-period expires after the eightieth bit | frame completes |
| `ST_GAP` | `ST_SETUP` | gap expires, continuous mode high | — |
| `ST_GAP` | `ST_IDLE` | gap expires, continuous mode low | — |

Top module: `sensor_poll_spi`

## Requirements
- R1: While `cs_n_o` is low, exactly 80 rising edges of `sclk_o` occur (10 bytes), and never more.
- R2: `sclk_o` is low whenever `cs_n_o` is high. `mosi_o` changes only in the cycle in which `sclk_o` rises. `miso_i` is sampled at the falling edge of `sclk_o`.
- R3: The transmitted frame is byte 0x55 followed by nine 0x00 bytes, each byte sent most significant bit first.
- R4: From `cs_n_o` falling to the first rising edge of `sclk_o`, exactly SETUP_CYC = ceil(SETUP_NS*CLK_KHZ/1e6) cycles pass. With the bench parameters (47 ns, 200000 kHz) this is 10.
- R5: Between frames, `cs_n_o` stays high for at least GAP_CYC = ceil(GAP_NS*CLK_KHZ/1e6) cycles. In continuous mode it stays high for exactly GAP_CYC cycles. With the bench parameters (1003 ns) this is 201.
- R6: Each high phase and each low phase of `sclk_o` inside a frame, including the last low phase before `cs_n_o` rises, lasts HALF_CYC cycles.
- R7: The k-th received byte (k = 0 first) is assembled MSB first and appears at `rx_frame_o[8k+7:8k]`. The output holds its value from one done pulse until the next.
- R8: `done_o` is a one-cycle pulse in the same cycle in which `cs_n_o` returns high. `rx_frame_o` is valid in that cycle.
- R9: Synchronous reset gives `cs_n_o`=1, `sclk_o`=0, `mosi_o`=0, `done_o`=0 and `rx_frame_o`=0. The block is then idle with the gap already satisfied, so a request in the first cycle after reset pulls `cs_n_o` low one cycle later.
- R10: A `start_i` pulse that arrives while a frame or the recovery gap is in progress is dropped and starts no extra frame.
- R11: While `cont_i` is high, a new frame starts when the gap expires. If `cont_i` is low when the gap expires, the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Single-frame request, sampled in idle |
| cont_i | input | 1 | Continuous polling enable |
| miso_i | input | 1 | Serial data from the sensor |
| sclk_o | output | 1 | Serial clock, idle low |
| cs_n_o | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the sensor |
| rx_frame_o | output | 8*FRAME_BYTES | Last received frame, byte k at bits 8k+7:8k |
| done_o | output | 1 | One-cycle frame-complete strobe |

## Verification
The outputs are registered from the next state, so `cs_n_o` falls one cycle after a request is seen in idle. The first clock rise follows SETUP_CYC cycles later. Each clock phase lasts HALF_CYC cycles. `done_o` rises together with `cs_n_o` at the end of the last low phase, and the following frame may start no sooner than GAP_CYC cycles after that.

The bench samples on the falling system-clock edge and measures each of these intervals with run-length counters, comparing them against the literal cycle counts that the requirements give. A scoreboard queues each frame's expected response when the sensor model is loaded, and pops the entry when the done pulse arrives. Dropped requests are checked by counting chip-select falls over a window longer than the gap.

// File: rtl/sensor_poll_pkg.sv
package sensor_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } poll_state_t;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_khz);
        logic [63:0] q;
        q = (64'(ns) * 64'(clk_khz) + 64'd999_999) / 64'd1_000_000;
        if (q == 64'd0) q = 64'd1;
        return q[31:0];
    endfunction

endpackage

// File: rtl/poll_interval_timer.sv
module poll_interval_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    // Loading N-1 keeps the owning state active for N cycles.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/poll_frame_shift.sv
module poll_frame_shift #(
    parameter int unsigned FRAME_BYTES = 10,
    parameter logic [7:0]  CMD_BYTE    = 8'h55
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     reload_i,
    input  logic                     drive_i,
    input  logic                     sample_i,
    input  logic                     commit_i,
    input  logic                     miso_i,
    output logic                     mosi_o,
    output logic [8*FRAME_BYTES-1:0] frame_o
);

    localparam int unsigned FRAME_BITS = 8 * FRAME_BYTES;
    localparam logic [FRAME_BITS-1:0] TX_IMAGE = {CMD_BYTE, {(FRAME_BITS-8){1'b0}}};

    logic [FRAME_BITS-1:0] tx_sh;
    logic [FRAME_BITS-1:0] rx_sh;
    logic [FRAME_BITS-1:0] rx_ordered;
    logic                  mosi_q;
    logic [FRAME_BITS-1:0] frame_q;

    // Transmit side: the MSB leaves first, and the register refills with zeros.
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh  <= TX_IMAGE;
            mosi_q <= 1'b0;
        end else if (reload_i) begin
            tx_sh  <= TX_IMAGE;
        end else if (drive_i) begin
            mosi_q <= tx_sh[FRAME_BITS-1];
            tx_sh  <= {tx_sh[FRAME_BITS-2:0], 1'b0};
        end
    end

    // Receive side: the first bit ends up at the top of rx_sh.
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh <= '0;
        end else if (sample_i) begin
            rx_sh <= {rx_sh[FRAME_BITS-2:0], miso_i};
        end
    end

    // Byte reversal so that the first received byte lands in the lowest lane.
    for (genvar k = 0; k < FRAME_BYTES; k++) begin : g_lane
        assign rx_ordered[8*k +: 8] = rx_sh[8*(FRAME_BYTES-1-k) +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (commit_i) begin
            frame_q <= rx_ordered;
        end
    end

    assign mosi_o  = mosi_q;
    assign frame_o = frame_q;

endmodule

// File: rtl/sensor_poll_spi.sv
module sensor_poll_spi
    import sensor_poll_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 200_000,
    parameter int unsigned SETUP_NS    = 6_900,
    parameter int unsigned GAP_NS      = 1_500_000,
    parameter int unsigned HALF_CYC    = 50,
    parameter int unsigned FRAME_BYTES = 10,
    parameter logic [7:0]  CMD_BYTE    = 8'h55
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     cont_i,
    input  logic                     miso_i,
    output logic                     sclk_o,
    output logic                     cs_n_o,
    output logic                     mosi_o,
    output logic [8*FRAME_BYTES-1:0] rx_frame_o,
    output logic                     done_o
);

    localparam int unsigned SETUP_CYC  = ns_to_cyc(SETUP_NS, CLK_KHZ);
    localparam int unsigned GAP_CYC    = ns_to_cyc(GAP_NS, CLK_KHZ);
    localparam int unsigned HALF_EFF   = (HALF_CYC < 1) ? 1 : HALF_CYC;
    localparam int unsigned FRAME_BITS = 8 * FRAME_BYTES;
    localparam int unsigned MAX_A      = (SETUP_CYC > GAP_CYC) ? SETUP_CYC : GAP_CYC;
    localparam int unsigned MAX_CYC    = (MAX_A > HALF_EFF) ? MAX_A : HALF_EFF;
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
    localparam int unsigned BIT_W      = $clog2(FRAME_BITS);

    localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD   = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_EFF - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    poll_state_t      state_q, state_n;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             tx_reload, bit_drive, bit_sample, frame_end;
    logic             bit_clr, bit_inc;
    logic [BIT_W-1:0] bit_idx_q;
    logic             last_bit;
    logic             cs_n_q, sclk_q, done_q;

    poll_interval_timer #(.CNT_W(CNT_W)) timer_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    poll_frame_shift #(.FRAME_BYTES(FRAME_BYTES), .CMD_BYTE(CMD_BYTE)) shift_i (
        .clk      (clk),
        .rst      (rst),
        .reload_i (tx_reload),
        .drive_i  (bit_drive),
        .sample_i (bit_sample),
        .commit_i (frame_end),
        .miso_i   (miso_i),
        .mosi_o   (mosi_o),
        .frame_o  (rx_frame_o)
    );

    assign last_bit = (bit_idx_q == LAST_BIT);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_n;
    end

    // Bit position within the frame
    always_ff @(posedge clk) begin
        if (rst || bit_clr) bit_idx_q <= '0;
        else if (bit_inc)   bit_idx_q <= bit_idx_q + 1'b1;
    end

    // Transitions and per-transition strobes
    always_comb begin
        state_n    = state_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        tx_reload  = 1'b0;
        bit_drive  = 1'b0;
        bit_sample = 1'b0;
        frame_end  = 1'b0;
        bit_clr    = 1'b0;
        bit_inc    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i || cont_i) begin
                    state_n   = ST_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = SETUP_LD;
                    tx_reload = 1'b1;
                    bit_clr   = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_n   = ST_HIGH;
                    tmr_load  = 1'b1;
                    tmr_val   = HALF_LD;
                    bit_drive = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_expired) begin
                    state_n    = ST_LOW;
                    tmr_load   = 1'b1;
                    tmr_val    = HALF_LD;
                    bit_sample = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    tmr_load = 1'b1;
                    if (last_bit) begin
                        state_n   = ST_GAP;
                        tmr_val   = GAP_LD;
                        frame_end = 1'b1;
                    end else begin
                        state_n   = ST_HIGH;
                        tmr_val   = HALF_LD;
                        bit_drive = 1'b1;
                        bit_inc   = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    if (cont_i) begin
                        state_n   = ST_SETUP;
                        tmr_load  = 1'b1;
                        tmr_val   = SETUP_LD;
                        tx_reload = 1'b1;
                        bit_clr   = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Registered pin outputs, taken from the next state
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n_q <= 1'b1;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            cs_n_q <= !(state_n == ST_SETUP || state_n == ST_HIGH || state_n == ST_LOW);
            sclk_q <= (state_n == ST_HIGH);
            done_q <= frame_end;
        end
    end

    assign cs_n_o = cs_n_q;
    assign sclk_o = sclk_q;
    assign done_o = done_q;

endmodule

// File: rtl/sensor_poll_spi_chk.sv
module sensor_poll_spi_chk
    import sensor_poll_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 200_000,
    parameter int unsigned SETUP_NS    = 6_900,
    parameter int unsigned GAP_NS      = 1_500_000,
    parameter int unsigned FRAME_BYTES = 10
) (
    input logic clk,
    input logic rst,
    input logic cs_n_o,
    input logic sclk_o,
    input logic mosi_o,
    input logic done_o
);

    localparam int unsigned SETUP_CYC  = ns_to_cyc(SETUP_NS, CLK_KHZ);
    localparam int unsigned GAP_CYC    = ns_to_cyc(GAP_NS, CLK_KHZ);
    localparam int unsigned FRAME_BITS = 8 * FRAME_BYTES;

    int unsigned setup_cnt, gap_cnt, edge_cnt;
    logic        sclk_seen, sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_cnt <= 0;
            gap_cnt   <= GAP_CYC;
            edge_cnt  <= 0;
            sclk_seen <= 1'b0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= sclk_o;
            if (cs_n_o) begin
                setup_cnt <= 0;
                sclk_seen <= 1'b0;
                edge_cnt  <= 0;
                gap_cnt   <= (gap_cnt >= GAP_CYC) ? GAP_CYC : gap_cnt + 1;
            end else begin
                gap_cnt <= 0;
                if (sclk_o && !sclk_prev) edge_cnt <= edge_cnt + 1;
                if (!sclk_seen) begin
                    if (sclk_o) sclk_seen <= 1'b1;
                    else        setup_cnt <= (setup_cnt >= SETUP_CYC) ? SETUP_CYC : setup_cnt + 1;
                end
            end
        end
    end

    // R1
    edge_limit_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> edge_cnt <= FRAME_BITS);

    // R2
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    // R2
    mosi_launch_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(sclk_o) |-> $stable(mosi_o));

    // R4
    setup_time_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(sclk_o) && !sclk_seen) |-> setup_cnt >= SETUP_CYC);

    // R5
    gap_time_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> gap_cnt >= GAP_CYC);

    // R8
    done_width_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    done_align_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $rose(cs_n_o));

endmodule

bind sensor_poll_spi sensor_poll_spi_chk #(
    .CLK_KHZ     (CLK_KHZ),
    .SETUP_NS    (SETUP_NS),
    .GAP_NS      (GAP_NS),
    .FRAME_BYTES (FRAME_BYTES)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .cs_n_o (cs_n_o),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .done_o (done_o)
);

// File: tb/sensor_poll_spi_tb_top.sv
module sensor_poll_spi_tb_top;

    localparam int NBYTES    = 10;
    localparam int NBITS     = 80;
    localparam int HALF      = 2;
    localparam int SETUP_EXP = 10;   // ceil(47 * 200000 / 1e6)
    localparam int GAP_EXP   = 201;  // ceil(1003 * 200000 / 1e6)

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic cont_i = 1'b0;
    logic miso = 1'b0;
    logic sclk_o, cs_n_o, mosi_o, done_o;
    logic [NBITS-1:0] rx_frame_o;

    always #2.5 clk = ~clk;

    sensor_poll_spi #(
        .CLK_KHZ(200_000), .SETUP_NS(47), .GAP_NS(1003), .HALF_CYC(HALF),
        .FRAME_BYTES(NBYTES), .CMD_BYTE(8'h55)
    ) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .cont_i(cont_i), .miso_i(miso),
        .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o),
        .rx_frame_o(rx_frame_o), .done_o(done_o)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [NBITS-1:0] resp_q[$];
    logic [NBITS-1:0] exp_q[$];
    logic [NBITS-1:0] cur_resp;
    logic [NBITS-1:0] cmd_cap;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_frame(input string req, input logic [NBITS-1:0] act,
                             input logic [NBITS-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s frame: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [NBITS-1:0] mk_resp(input logic [7:0] seed);
        logic [NBITS-1:0] f;
        for (int k = 0; k < NBYTES; k++) f[8*k +: 8] = seed ^ 8'(k * 8'h1D);
        return f;
    endfunction

    // Driver side of the scoreboard: loads the sensor model and the expectation.
    task automatic push_resp(input logic [7:0] seed);
        resp_q.push_back(mk_resp(seed));
        exp_q.push_back(mk_resp(seed));
    endtask

    // Sensor model: launches on rising SCLK, captures MOSI on falling SCLK.
    initial begin
        forever begin
            @(negedge cs_n_o);
            cur_resp = (resp_q.size() > 0) ? resp_q.pop_front() : '0;
            cmd_cap  = '0;
            for (int b = 0; b < NBITS; b++) begin
                @(posedge sclk_o);
                miso <= cur_resp[8*(b/8) + 7 - (b%8)];
                @(negedge sclk_o);
                cmd_cap[8*(b/8) + 7 - (b%8)] = mosi_o;
            end
        end
    end

    // Monitor: samples away from the active edge.
    int  frames_started = 0, done_count = 0;
    int  setup_run, gap_run = 100000, rise_cnt, high_run, low_run, half_bad, hold_bad = 0;
    bit  first_seen, prev_cs = 1, prev_sclk = 0, done_prev = 0, exact_gap = 0;
    logic [NBITS-1:0] last_frame = '0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (done_o) begin
                // R8: one cycle wide, coincides with cs_n rising
                chk(!done_prev && prev_cs == 1'b0 && cs_n_o == 1'b1, "R8", "done alignment",
                    {done_prev, prev_cs, cs_n_o}, 3'b001);
                // R7: scoreboard compare
                if (exp_q.size() == 0) chk(0, "R7", "unexpected done", 1, 0);
                else chk_frame("R7", rx_frame_o, exp_q.pop_front());
                last_frame = rx_frame_o;
                done_count++;
            end else if (rx_frame_o !== last_frame) begin
                hold_bad++;
            end
            done_prev = done_o;

            if (prev_cs && !cs_n_o) begin
                chk(sclk_o == 1'b0, "R2", "sclk at cs fall", sclk_o, 0);
                if (frames_started > 0) begin
                    chk(gap_run >= GAP_EXP, "R5", "gap minimum", gap_run, GAP_EXP);
                    if (exact_gap) chk(gap_run == GAP_EXP, "R5", "continuous gap", gap_run, GAP_EXP);
                end
                frames_started++;
                setup_run = 0; first_seen = 0; rise_cnt = 0;
                high_run = 0; low_run = 0; half_bad = 0;
            end

            if (!cs_n_o) begin
                if (!first_seen) begin
                    if (!sclk_o) setup_run++;
                    else begin
                        chk(setup_run == SETUP_EXP, "R4", "setup cycles", setup_run, SETUP_EXP);
                        first_seen = 1; rise_cnt = 1; high_run = 1;
                    end
                end else if (sclk_o) begin
                    if (!prev_sclk) begin
                        if (low_run != HALF) half_bad++;
                        rise_cnt++; high_run = 1;
                    end else high_run++;
                end else begin
                    if (prev_sclk) begin
                        if (high_run != HALF) half_bad++;
                        low_run = 1;
                    end else low_run++;
                end
            end

            if (!prev_cs && cs_n_o) begin
                if (low_run != HALF) half_bad++;
                chk(rise_cnt == NBITS, "R1", "sclk rises per frame", rise_cnt, NBITS);
                chk(half_bad == 0, "R6", "half-period violations", half_bad, 0);
                chk_frame("R3", cmd_cap, 80'h55);
                chk(hold_bad == 0, "R7", "output changed between dones", hold_bad, 0);
                hold_bad = 0;
                gap_run = 1;
            end else if (cs_n_o) begin
                gap_run++;
            end

            prev_cs = cs_n_o;
            prev_sclk = sclk_o;
        end
    end

    task automatic wait_done();
        int target;
        target = done_count + 1;
        while (done_count < target) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic summary();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired: actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk(cs_n_o == 1'b1, "R9", "cs_n after reset", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R9", "sclk after reset", sclk_o, 0);
        chk(mosi_o == 1'b0 && done_o == 1'b0, "R9", "mosi/done after reset", {mosi_o, done_o}, 0);
        chk_frame("R9", rx_frame_o, '0);
        // R9: gap already satisfied, frame starts at once
        push_resp(8'hA5);
        pulse_start();
        chk(cs_n_o == 1'b0, "R9", "cs_n one cycle after start", cs_n_o, 0);
        wait_done();

        // Second frame, with requests during the frame and during the gap (R10)
        push_resp(8'h3C);
        repeat (300) @(negedge clk);
        pulse_start();
        repeat (100) @(negedge clk);
        pulse_start();
        wait_done();
        repeat (50) @(negedge clk);
        pulse_start();
        repeat (400) @(negedge clk);
        chk(frames_started == 2, "R10", "frames after dropped starts", frames_started, 2);
        chk(cs_n_o == 1'b1, "R10", "cs_n idle", cs_n_o, 1);

        // Continuous polling (R11, R5 exact gap)
        push_resp(8'h00);
        push_resp(8'hFF);
        push_resp(8'h96);
        cont_i = 1'b1;
        while (frames_started < 3) @(negedge clk);
        exact_gap = 1;
        while (done_count < 5) @(negedge clk);
        cont_i = 1'b0;
        repeat (400) @(negedge clk);
        chk(frames_started == 5, "R11", "frames in continuous run", frames_started, 5);
        chk(exp_q.size() == 0, "R11", "pending expected frames", exp_q.size(), 0);
        chk(cs_n_o == 1'b1, "R11", "idle after cont drop", cs_n_o, 1);
        summary();
    end

endmodule